// File: doc/BRIEF.md
# PCI Interrupt Router and Trigger

This block turns interrupt events raised by devices on a PCI-style bus into a single CPU interrupt line. Each event names a device slot and one of the four interrupt pins. A fixed table maps the slot and pin to an interrupt number. Mapped numbers start at a base of 32, so the 32 internal lines are numbers 32 to 63. The edge-mode and polarity vectors, supplied from an external register file, are then looked up for that internal line to decide how the CPU output moves.

The table works as follows:
- The south-bridge slot maps its pins one to one onto lines 0 to 3.
- The graphics slot shares line 4 across all its pins.
- The network slot shares line 5 across all its pins.
- The expansion slots 8 to 12 rotate their pins across lines 6 to 13.
- Any other slot passes the pin number through unchanged. That number lies below the base, so it names no internal line.

A line configured for edge mode produces a one-cycle high pulse on the output. A line in level mode drives the output to its polarity bit, and the output holds that value until the next qualifying event.

Top module: `irq_router`

## Requirements
- R1: While `rst_ni` is low and after it rises, `cpu_irq_o` is 0 until the first qualifying event.
- R2: Slot 5 maps pin n (0 to 3) to internal line n, which is interrupt number 32+n.
- R3: Slot 6 maps every pin to internal line 4, and slot 7 maps every pin to internal line 5.
- R4: Slots 8 to 12 map pin n to internal line (slot - 8 + n) + 6, giving lines 6 to 13.
- R5: An event from any other slot yields the number n (the pin), which is below the base of 32. Such an event reads no bit of `edge_mode_i` or `polarity_i` and leaves `cpu_irq_o` unchanged.
- R6: When `edge_mode_i[line]` is 1, an event drives `cpu_irq_o` high on the clock edge after the strobe, whatever the polarity bit is. The output returns low one cycle later unless another qualifying event arrives.
- R7: When `edge_mode_i[line]` is 0, an event sets `cpu_irq_o` to `polarity_i[line]` on the clock edge after the strobe. The output holds that value while no further qualifying event arrives.
- R8: Slot and pin values presented while `evt_valid_i` is 0 have no effect on `cpu_irq_o`.
- R9: Edge-mode events on consecutive cycles keep `cpu_irq_o` high for each of those cycles. The output falls one cycle after the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Qualifies the slot and pin of an interrupt event |
| evt_slot_i | input | 5 | Device slot number of the event |
| evt_pin_i | input | 2 | Interrupt pin of the device, 0 to 3 |
| edge_mode_i | input | 32 | Per-line mode, bit i for internal line i: 1 = pulse, 0 = level |
| polarity_i | input | 32 | Per-line level value used in level mode |
| cpu_irq_o | output | 1 | Interrupt output to the CPU |

## Verification
The bench builds the block with its default parameters: 5-bit slot numbers, 4 pins, 32 lines and a base of 32. With a 5-bit slot field, every slot from 0 to 31 can be driven, including slots 4, 13 and 31 just outside the mapped ranges. The default line count covers every mapped line from 0 to 13 with spare bits above it. Setting a single polarity bit in one step and clearing it in the next pins each slot and pin pair to exactly one line.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_PULSE = 2'd1,
    ACT_RAISE = 2'd2,
    ACT_LOWER = 2'd3
  } irq_act_e;
endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map #(
  parameter int SLOT_W       = 5,
  parameter int PIN_W        = 2,
  parameter int NUM_W        = 6,
  parameter int IRQ_BASE     = 32,
  parameter int SB_SLOT      = 5,
  parameter int GFX_SLOT     = 6,
  parameter int GFX_LINE     = 4,
  parameter int NIC_SLOT     = 7,
  parameter int NIC_LINE     = 5,
  parameter int EXP_FIRST    = 8,
  parameter int EXP_LAST     = 12,
  parameter int EXP_LINE_OFS = 6
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [PIN_W-1:0]  pin_i,
  output logic [NUM_W-1:0]  num_o
);
  localparam logic [NUM_W-1:0] EXP_BIAS = NUM_W'(IRQ_BASE + EXP_LINE_OFS - EXP_FIRST);

  always_comb begin
    if (slot_i == SLOT_W'(SB_SLOT))
      num_o = NUM_W'(IRQ_BASE) + NUM_W'(pin_i);
    else if (slot_i == SLOT_W'(GFX_SLOT))
      num_o = NUM_W'(IRQ_BASE + GFX_LINE);
    else if (slot_i == SLOT_W'(NIC_SLOT))
      num_o = NUM_W'(IRQ_BASE + NIC_LINE);
    else if (slot_i >= SLOT_W'(EXP_FIRST) && slot_i <= SLOT_W'(EXP_LAST))
      num_o = EXP_BIAS + NUM_W'(slot_i) + NUM_W'(pin_i);
    else
      num_o = NUM_W'(pin_i);  // pass-through, below base
  end
endmodule

// File: rtl/irq_cfg_sel.sv
module irq_cfg_sel #(
  parameter int NUM_W    = 6,
  parameter int LINES    = 32,
  parameter int IRQ_BASE = 32
) (
  input  logic [NUM_W-1:0] num_i,
  input  logic [LINES-1:0] edge_mode_i,
  input  logic [LINES-1:0] polarity_i,
  output logic             hit_o,
  output logic             edge_o,
  output logic             pol_o
);
  localparam int XW = NUM_W + 1;

  logic [XW-1:0]    num_x;
  logic [NUM_W-1:0] ofs;
  logic [LINES-1:0] sel;

  assign num_x = {1'b0, num_i};
  assign hit_o = (num_x >= XW'(IRQ_BASE)) && (num_x < XW'(IRQ_BASE + LINES));
  assign ofs   = num_i - NUM_W'(IRQ_BASE);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign sel[g] = hit_o && (ofs == NUM_W'(g));
  end

  assign edge_o = |(sel & edge_mode_i);
  assign pol_o  = |(sel & polarity_i);

  always_comb begin
    // R5
    line_sel_onehot_chk: assert ($onehot0(sel));
  end
endmodule

// File: rtl/irq_out_drv.sv
module irq_out_drv
  import irq_rt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic hit_i,
  input  logic edge_i,
  input  logic pol_i,
  output logic irq_o
);
  irq_act_e act;
  logic     irq_q, pulse_q;

  always_comb begin
    if (!evt_i || !hit_i) act = ACT_HOLD;
    else if (edge_i)      act = ACT_PULSE;
    else if (pol_i)       act = ACT_RAISE;
    else                  act = ACT_LOWER;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_PULSE: begin irq_q <= 1'b1; pulse_q <= 1'b1; end
        ACT_RAISE: begin irq_q <= 1'b1; pulse_q <= 1'b0; end
        ACT_LOWER: begin irq_q <= 1'b0; pulse_q <= 1'b0; end
        default: if (pulse_q) begin irq_q <= 1'b0; pulse_q <= 1'b0; end
      endcase
    end
  end

  assign irq_o = irq_q;

  // R6
  pulse_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == ACT_PULSE) |=> irq_o);
  // R6
  pulse_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q && act == ACT_HOLD) |=> !irq_o);
  // R7
  level_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == ACT_RAISE) |=> irq_o);
  // R7
  level_lower_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == ACT_LOWER) |=> !irq_o);
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !pulse_q) |=> $stable(irq_o));
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int SLOT_W       = 5,
  parameter int PIN_W        = 2,
  parameter int LINES        = 32,
  parameter int IRQ_BASE     = 32,
  parameter int SB_SLOT      = 5,
  parameter int GFX_SLOT     = 6,
  parameter int GFX_LINE     = 4,
  parameter int NIC_SLOT     = 7,
  parameter int NIC_LINE     = 5,
  parameter int EXP_FIRST    = 8,
  parameter int EXP_LAST     = 12,
  parameter int EXP_LINE_OFS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [SLOT_W-1:0] evt_slot_i,
  input  logic [PIN_W-1:0]  evt_pin_i,
  input  logic [LINES-1:0]  edge_mode_i,
  input  logic [LINES-1:0]  polarity_i,
  output logic              cpu_irq_o
);
  localparam int NUM_W = $clog2(IRQ_BASE + LINES);

  logic [NUM_W-1:0] irq_num;
  logic             hit, edge_bit, pol_bit;

  irq_slot_map #(
    .SLOT_W(SLOT_W), .PIN_W(PIN_W), .NUM_W(NUM_W), .IRQ_BASE(IRQ_BASE),
    .SB_SLOT(SB_SLOT), .GFX_SLOT(GFX_SLOT), .GFX_LINE(GFX_LINE),
    .NIC_SLOT(NIC_SLOT), .NIC_LINE(NIC_LINE), .EXP_FIRST(EXP_FIRST),
    .EXP_LAST(EXP_LAST), .EXP_LINE_OFS(EXP_LINE_OFS)
  ) u_map (
    .slot_i(evt_slot_i),
    .pin_i (evt_pin_i),
    .num_o (irq_num)
  );

  irq_cfg_sel #(
    .NUM_W(NUM_W), .LINES(LINES), .IRQ_BASE(IRQ_BASE)
  ) u_sel (
    .num_i      (irq_num),
    .edge_mode_i(edge_mode_i),
    .polarity_i (polarity_i),
    .hit_o      (hit),
    .edge_o     (edge_bit),
    .pol_o      (pol_bit)
  );

  irq_out_drv u_drv (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_valid_i),
    .hit_i (hit),
    .edge_i(edge_bit),
    .pol_i (pol_bit),
    .irq_o (cpu_irq_o)
  );

  // R5
  passthrough_below_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_slot_i < SLOT_W'(SB_SLOT) || evt_slot_i > SLOT_W'(EXP_LAST)) |-> !hit);
endmodule

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [4:0]  slot = '0;
  logic [1:0]  pin = '0;
  logic [31:0] edge_m = '0;
  logic [31:0] pol = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(valid), .evt_slot_i(slot),
    .evt_pin_i(pin), .edge_mode_i(edge_m), .polarity_i(pol), .cpu_irq_o(irq)
  );

  // {slot, pin, expected internal line}
  localparam logic [11:0] VEC [12] = '{
    {5'd5,  2'd0, 5'd0},  {5'd5,  2'd3, 5'd3},
    {5'd6,  2'd0, 5'd4},  {5'd6,  2'd2, 5'd4},
    {5'd7,  2'd1, 5'd5},  {5'd7,  2'd3, 5'd5},
    {5'd8,  2'd0, 5'd6},  {5'd8,  2'd3, 5'd9},
    {5'd10, 2'd2, 5'd10}, {5'd11, 2'd1, 5'd10},
    {5'd12, 2'd0, 5'd10}, {5'd12, 2'd3, 5'd13}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: cpu_irq_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic fire(input logic [4:0] s, input logic [1:0] p);
    @(negedge clk);
    slot = s; pin = p; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1
    repeat (3) @(negedge clk);
    check("R1 in reset", irq, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", irq, 1'b0);

    // R2 R3 R4: mapping table, level mode
    edge_m = '0;
    for (int i = 0; i < 12; i++) begin
      logic [4:0] s;
      logic [1:0] p;
      logic [4:0] ln;
      string tag;
      {s, p, ln} = VEC[i];
      tag = (s == 5'd5) ? "R2" : (s <= 5'd7) ? "R3" : "R4";
      pol = 32'd1 << ln;
      fire(s, p);
      check($sformatf("%s slot %0d pin %0d high", tag, s, p), irq, 1'b1);
      pol = ~(32'd1 << ln);
      fire(s, p);
      check($sformatf("%s slot %0d pin %0d low", tag, s, p), irq, 1'b0);
    end

    // R5: pass-through slots leave output unchanged
    pol = '1;
    fire(5'd6, 2'd0);
    check("R5 setup high", irq, 1'b1);
    pol = '0;
    fire(5'd4, 2'd1);
    check("R5 slot 4 ignored", irq, 1'b1);
    fire(5'd13, 2'd0);
    check("R5 slot 13 ignored", irq, 1'b1);
    fire(5'd31, 2'd3);
    check("R5 slot 31 ignored", irq, 1'b1);
    fire(5'd6, 2'd0);
    check("R5 setup low", irq, 1'b0);
    pol = '1;
    edge_m = '1;
    fire(5'd0, 2'd2);
    check("R5 slot 0 ignored", irq, 1'b0);
    @(negedge clk);
    check("R5 slot 0 no pulse", irq, 1'b0);
    edge_m = '0;

    // R8: no strobe, no change
    slot = 5'd6; pin = 2'd1; valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 unstrobed", irq, 1'b0);

    // R7: level holds
    pol = 32'd1 << 5;
    fire(5'd7, 2'd2);
    check("R7 raise", irq, 1'b1);
    repeat (4) @(negedge clk);
    check("R7 hold high", irq, 1'b1);
    pol = '0;
    fire(5'd7, 2'd0);
    check("R7 lower", irq, 1'b0);
    repeat (4) @(negedge clk);
    check("R7 hold low", irq, 1'b0);

    // R6: single pulse, polarity ignored
    edge_m = 32'd1 << 5;
    pol = '0;
    fire(5'd7, 2'd1);
    check("R6 pulse high", irq, 1'b1);
    @(negedge clk);
    check("R6 pulse ends", irq, 1'b0);
    @(negedge clk);
    check("R6 stays low", irq, 1'b0);
    // R6: edge bit only on line 4; line 5 in level mode
    edge_m = 32'd1 << 4;
    pol = 32'd1 << 5;
    fire(5'd6, 2'd3);
    check("R6 line 4 pulse", irq, 1'b1);
    @(negedge clk);
    check("R6 line 4 pulse ends", irq, 1'b0);
    fire(5'd7, 2'd3);
    check("R7 line 5 level", irq, 1'b1);
    @(negedge clk);
    check("R7 line 5 no fall", irq, 1'b1);
    pol = '0;
    fire(5'd7, 2'd3);
    check("R7 line 5 lowered", irq, 1'b0);

    // R9: back-to-back pulses
    edge_m = '1;
    @(negedge clk);
    slot = 5'd8; pin = 2'd0; valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 back-to-back high", irq, 1'b1);
    end
    valid = 1'b0;
    @(negedge clk);
    check("R9 falls after last", irq, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule